// File: doc/BRIEF.md
# Read-Modify-Write Bus Sequencer

This unit carries out the memory phase of an 8-bit processor's read-modify-write instructions. A start pulse hands it an operation code, an effective address, the incoming carry and overflow flags, and the accumulator. It then reads the operand from a simple synchronous bus. It writes that operand back unchanged, and on the very next cycle it writes the modified operand to the same address. It finishes with a one-cycle done pulse. The modification is a shift, a rotate, an increment or a decrement.

Setting the upper bit of the operation code selects a combined instruction. In that case the modified operand also feeds one accumulator step: OR, AND, XOR, add with carry, compare, or subtract with borrow. The accumulator and the four flags that result stay on the output pins until the next sequence completes.

The bus has no handshake. The memory must return read data in the same cycle as the read strobe. Writes take effect at the clock edge that ends the write cycle. The start input is a plain control pulse. It is taken only while the unit is idle, and a sequence cannot be stalled once it has begun.

Top module: `rmw_sequencer`

## Requirements
- R1: After reset, bus_rd, bus_wr and done are low, and acc_out and all four flag outputs are 0.
- R2: A start accepted in idle produces this sequence on the following cycles: one cycle with bus_rd high, two cycles with bus_wr high, then one cycle with done high. bus_rd and bus_wr are never high in the same cycle.
- R3: The first write goes to the address that was read and carries the byte returned by the read, unchanged.
- R4: The second write follows the first on the next cycle, at the same address, and carries the modified byte. op_code[2:0] selects the modification: 0 shift left (bit 0 gets 0), 1 rotate left through carry, 2 logical shift right, 3 rotate right through carry, 4 decrement, 5 increment.
- R5: A rotate takes carry_in into the vacated bit; a shift ignores carry_in. For example, with operand 0x25: shift left gives 0x4A, rotate left gives 0x4A or 0x4B (carry clear or set), shift right gives 0x12, rotate right gives 0x12 or 0x92, decrement gives 0x24, increment gives 0x26.
- R6: With op_code[3]=0, flag_c is the bit shifted out (carry_in for increment and decrement). flag_z and flag_n follow the written byte, flag_v equals v_in, and acc_out equals acc_in.
- R7: With op_code[3]=1 and codes 0, 1 or 2, acc_out is acc_in OR, AND or XOR the written byte. flag_z and flag_n follow acc_out, flag_c is the bit shifted out, and flag_v equals v_in.
- R8: Combined code 3 adds acc_in, the written byte and the rotate's carry-out in binary. It gives the carry-out of the sum and the two's-complement overflow, with Z and N taken from the sum.
- R9: Combined code 4 compares acc_in with the written byte. flag_c is set when acc_in is greater than or equal to the byte, flag_z when they are equal, and flag_n is bit 7 of their difference. acc_out equals acc_in.
- R10: Combined code 5 computes acc_in minus the written byte minus (1 - carry_in) in binary. flag_c is set when no borrow occurs, flag_v reports two's-complement overflow, and Z and N follow the result.
- R11: A start that arrives while a sequence is in progress is ignored. It adds no bus cycle and no done pulse, and its operands do not change the results of the sequence already running.
- R12: A start with op_code[2:0] equal to 6 or 7 is ignored: there is no bus activity and no done pulse, and acc_out and the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (taken only while idle) |
| op_code | input | 4 | [3] combined step, [2:0] memory modification |
| addr_in | input | 16 | Effective address of the operand |
| carry_in | input | 1 | Incoming carry flag |
| v_in | input | 1 | Incoming overflow flag |
| acc_in | input | 8 | Incoming accumulator |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid during the read cycle |
| done | output | 1 | One-cycle completion pulse |
| acc_out | output | 8 | Resulting accumulator |
| flag_c | output | 1 | Resulting carry |
| flag_z | output | 1 | Resulting zero |
| flag_n | output | 1 | Resulting negative |
| flag_v | output | 1 | Resulting overflow |

## Verification
Every modification runs on the operand 0x25 twice, once with carry clear and once with carry set. This separates the rotates, which must pick up the carry, from the shifts, which must not. Wrap operands (decrement of 0x00, increment of 0xFF, rotate of 0x80) show whether zero, negative and carry-out are derived from the written byte. The combined steps use accumulators chosen to produce signed overflow, equal and unequal compares, and a borrow. Starts issued mid-sequence and starts with reserved codes must leave the bus transaction stream unchanged.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  typedef enum logic [2:0] {
    MOP_SHL = 3'd0,
    MOP_ROL = 3'd1,
    MOP_SHR = 3'd2,
    MOP_ROR = 3'd3,
    MOP_DEC = 3'd4,
    MOP_INC = 3'd5
  } mem_op_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WR1  = 3'd2,
    ST_WR2  = 3'd3,
    ST_FIN  = 3'd4
  } seq_st_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/rmw_memop.sv
module rmw_memop
  import rmw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] din,
  input  mem_op_e       op,
  input  logic          cin,
  output logic [DW-1:0] dout,
  output logic          cout
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  always_comb begin
    dout = din;
    cout = cin;
    case (op)
      MOP_SHL: begin dout = {din[DW-2:0], 1'b0}; cout = din[DW-1]; end
      MOP_ROL: begin dout = {din[DW-2:0], cin};  cout = din[DW-1]; end
      MOP_SHR: begin dout = {1'b0, din[DW-1:1]}; cout = din[0];    end
      MOP_ROR: begin dout = {cin, din[DW-1:1]};  cout = din[0];    end
      MOP_DEC: dout = din - ONE;
      MOP_INC: dout = din + ONE;
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/rmw_accstep.sv
module rmw_accstep
  import rmw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          combine,
  input  mem_op_e       op,
  input  logic [DW-1:0] mval,
  input  logic          mcarry,
  input  logic [DW-1:0] acc,
  input  logic          vin,
  output logic [DW-1:0] acc_o,
  output flags_t        fl
);
  localparam logic [DW:0] CIN_ONE = {{DW{1'b0}}, 1'b1};

  logic [DW:0] sum_w;
  logic [DW:0] dif_w;
  logic [DW:0] cmp_w;

  assign sum_w = {1'b0, acc} + {1'b0, mval}  + {{DW{1'b0}}, mcarry};
  assign dif_w = {1'b0, acc} + {1'b0, ~mval} + {{DW{1'b0}}, mcarry};
  assign cmp_w = {1'b0, acc} + {1'b0, ~mval} + CIN_ONE;

  always_comb begin
    acc_o = acc;
    fl.c  = mcarry;
    fl.v  = vin;
    fl.z  = (mval == '0);
    fl.n  = mval[DW-1];
    if (combine) begin
      case (op)
        MOP_SHL: acc_o = acc | mval;
        MOP_ROL: acc_o = acc & mval;
        MOP_SHR: acc_o = acc ^ mval;
        MOP_ROR: begin
          acc_o = sum_w[DW-1:0];
          fl.c  = sum_w[DW];
          fl.v  = (~(acc[DW-1] ^ mval[DW-1])) & (acc[DW-1] ^ sum_w[DW-1]);
        end
        MOP_DEC: acc_o = acc;
        MOP_INC: begin
          acc_o = dif_w[DW-1:0];
          fl.c  = dif_w[DW];
          fl.v  = (acc[DW-1] ^ mval[DW-1]) & (acc[DW-1] ^ dif_w[DW-1]);
        end
        default: acc_o = acc;
      endcase
      if (op == MOP_DEC) begin
        fl.c = cmp_w[DW];
        fl.z = (cmp_w[DW-1:0] == '0);
        fl.n = cmp_w[DW-1];
      end else begin
        fl.z = (acc_o == '0);
        fl.n = acc_o[DW-1];
      end
    end
  end
endmodule

// File: rtl/rmw_seq_ctrl.sv
module rmw_seq_ctrl
  import rmw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    op_ok,
  output logic    accept,
  output seq_st_e st
);
  seq_st_e st_nx;

  assign accept = (st == ST_IDLE) && start && op_ok;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (accept) st_nx = ST_RD;
      ST_RD:   st_nx = ST_WR1;
      ST_WR1:  st_nx = ST_WR2;
      ST_WR2:  st_nx = ST_FIN;
      ST_FIN:  st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD) |=> (st == ST_WR1)); // R2
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && st != ST_FIN && start) |=> (st != ST_RD)); // R11
  AST_BAD_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !op_ok) |=> (st == ST_IDLE)); // R12
endmodule

// File: rtl/rmw_sequencer.sv
module rmw_sequencer
  import rmw_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    op_code,
  input  logic [AW-1:0] addr_in,
  input  logic          carry_in,
  input  logic          v_in,
  input  logic [DW-1:0] acc_in,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          done,
  output logic [DW-1:0] acc_out,
  output logic          flag_c,
  output logic          flag_z,
  output logic          flag_n,
  output logic          flag_v
);
  localparam logic [2:0] LAST_CODE = 3'(MOP_INC);

  seq_st_e       st;
  logic          accept;
  logic          op_ok;
  mem_op_e       op_q;
  logic          comb_q;
  logic [AW-1:0] addr_q;
  logic          cin_q;
  logic          vin_q;
  logic [DW-1:0] acc_q;
  logic [DW-1:0] data_q;
  logic [DW-1:0] mval;
  logic          mcarry;
  logic [DW-1:0] acc_nx;
  flags_t        fl_nx;
  flags_t        fl_q;
  logic [DW-1:0] acc_r;

  assign op_ok = (op_code[2:0] <= LAST_CODE);

  rmw_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op_ok(op_ok),
    .accept(accept), .st(st)
  );

  rmw_memop #(.DW(DW)) u_memop (
    .din(data_q), .op(op_q), .cin(cin_q), .dout(mval), .cout(mcarry)
  );

  rmw_accstep #(.DW(DW)) u_acc (
    .combine(comb_q), .op(op_q), .mval(mval), .mcarry(mcarry),
    .acc(acc_q), .vin(vin_q), .acc_o(acc_nx), .fl(fl_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= MOP_SHL;
      comb_q <= 1'b0;
      addr_q <= '0;
      cin_q  <= 1'b0;
      vin_q  <= 1'b0;
      acc_q  <= '0;
      data_q <= '0;
      acc_r  <= '0;
      fl_q   <= '0;
    end else begin
      if (accept) begin
        op_q   <= mem_op_e'(op_code[2:0]);
        comb_q <= op_code[3];
        addr_q <= addr_in;
        cin_q  <= carry_in;
        vin_q  <= v_in;
        acc_q  <= acc_in;
      end
      if (st == ST_RD) data_q <= bus_rdata;
      if (st == ST_WR2) begin
        acc_r <= acc_nx;
        fl_q  <= fl_nx;
      end
    end
  end

  assign bus_addr  = addr_q;
  assign bus_rd    = (st == ST_RD);
  assign bus_wr    = (st == ST_WR1) || (st == ST_WR2);
  assign bus_wdata = (st == ST_WR2) ? mval : data_q;
  assign done      = (st == ST_FIN);
  assign acc_out   = acc_r;
  assign flag_c    = fl_q.c;
  assign flag_z    = fl_q.z;
  assign flag_n    = fl_q.n;
  assign flag_v    = fl_q.v;

  AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr)); // R2
  AST_FIRST_WRITE_ORIGINAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr) |-> ($past(bus_rd) && bus_wdata == $past(bus_rdata)
                       && bus_addr == $past(bus_addr))); // R3
  AST_SECOND_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr) |=> (bus_wr && $stable(bus_addr))); // R4
  AST_DONE_AFTER_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(bus_wr) && !bus_wr && !bus_rd)); // R2
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(done)) |-> $stable(acc_out)); // R12
endmodule

// File: tb/rmw_sequencer_tb.sv
module rmw_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op_code = '0;
  logic [15:0] addr_in = '0;
  logic        carry_in = 1'b0;
  logic        v_in = 1'b0;
  logic [7:0]  acc_in = '0;
  logic [15:0] bus_addr;
  logic        bus_rd, bus_wr, done;
  logic [7:0]  bus_wdata, bus_rdata, acc_out;
  logic        flag_c, flag_z, flag_n, flag_v;

  int checks = 0;
  int errors = 0;
  int events = 0;

  logic [7:0] mem [0:255];

  typedef struct {
    int         kind;   // 0 read, 1 write, 2 done
    logic [15:0] addr;
    logic [7:0]  data;
    logic [7:0]  acc;
    logic [3:0]  flg;   // {n,v,z,c}
    string       req;
  } item_t;

  item_t exp_q[$];

  always #10 clk = ~clk;

  rmw_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
    .addr_in(addr_in), .carry_in(carry_in), .v_in(v_in), .acc_in(acc_in),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done(done),
    .acc_out(acc_out), .flag_c(flag_c), .flag_z(flag_z),
    .flag_n(flag_n), .flag_v(flag_v)
  );

  assign bus_rdata = mem[bus_addr[7:0]];
  always @(posedge clk) if (bus_wr) mem[bus_addr[7:0]] <= bus_wdata;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // Monitor: pops one expected item per observed bus/done cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_rd && bus_wr) check(1'b0, "R2", "rd and wr together", 1, 0);
      if (bus_rd || bus_wr || done) begin
        item_t it;
        int kind;
        events++;
        kind = bus_rd ? 0 : (bus_wr ? 1 : 2);
        if (exp_q.size() == 0) begin
          check(1'b0, "R11", "unexpected bus event", kind, 99);
        end else begin
          it = exp_q.pop_front();
          check(kind == it.kind, it.req, "cycle kind", kind, it.kind);
          if (it.kind == 0)
            check(bus_addr == it.addr, it.req, "read addr", bus_addr, it.addr);
          if (it.kind == 1) begin
            check(bus_addr == it.addr, it.req, "write addr", bus_addr, it.addr);
            check(bus_wdata == it.data, it.req, "write data", bus_wdata, it.data);
          end
          if (it.kind == 2) begin
            check(acc_out == it.acc, it.req, "acc_out", acc_out, it.acc);
            check({flag_n, flag_v, flag_z, flag_c} == it.flg, it.req, "flags nvzc",
                  {flag_n, flag_v, flag_z, flag_c}, it.flg);
          end
        end
      end
    end
  end

  function automatic void ref_calc(input logic [3:0] op, input logic [7:0] d,
                                   input bit cin, input bit vin, input logic [7:0] a,
                                   output logic [7:0] m, output logic [7:0] ao,
                                   output logic [3:0] fl);
    bit c, v, z, n;
    int sa, sm, ss, u;
    c = cin; v = vin; ao = a;
    case (op[2:0])
      3'd0: begin m = d << 1; c = d[7]; end
      3'd1: begin m = (d << 1) | {7'd0, cin}; c = d[7]; end
      3'd2: begin m = d >> 1; c = d[0]; end
      3'd3: begin m = (d >> 1) | {cin, 7'd0}; c = d[0]; end
      3'd4: m = 8'(d - 8'd1);
      default: m = 8'(d + 8'd1);
    endcase
    z = (m == 0); n = m[7];
    if (op[3]) begin
      sa = $signed(a); sm = $signed(m);
      case (op[2:0])
        3'd0: ao = a | m;
        3'd1: ao = a & m;
        3'd2: ao = a ^ m;
        3'd3: begin
          u = int'(a) + int'(m) + int'(c);
          ss = sa + sm + int'(c);
          ao = u[7:0]; c = (u > 255); v = (ss > 127) || (ss < -128);
        end
        3'd4: begin ao = a; end
        default: begin
          u = int'(a) - int'(m) - (1 - int'(c));
          ss = sa - sm - (1 - int'(c));
          ao = u[7:0]; c = (u >= 0); v = (ss > 127) || (ss < -128);
        end
      endcase
      if (op[2:0] == 3'd4) begin
        u = int'(a) - int'(m);
        c = (a >= m); z = (a == m); n = u[7];
      end else begin
        z = (ao == 0); n = ao[7];
      end
    end
    fl = {n, v, z, c};
  endfunction

  // Driver: seed memory, push expected items, pulse start, wait out the run
  task automatic run_op(input logic [3:0] op, input logic [15:0] a,
                        input logic [7:0] d, input bit cin, input bit vin,
                        input logic [7:0] acc, input string req);
    logic [7:0] m, ao;
    logic [3:0] fl;
    item_t it;
    ref_calc(op, d, cin, vin, acc, m, ao, fl);
    mem[a[7:0]] = d;
    it.addr = a; it.acc = ao; it.flg = fl; it.req = req;
    it.kind = 0; it.data = 0; exp_q.push_back(it);
    it.kind = 1; it.data = d; it.req = {req, "/R3"}; exp_q.push_back(it);
    it.kind = 1; it.data = m; it.req = {req, "/R4"}; exp_q.push_back(it);
    it.kind = 2; it.data = 0; it.req = req; exp_q.push_back(it);
    op_code = op; addr_in = a; carry_in = cin; v_in = vin; acc_in = acc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    int ev0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!bus_rd && !bus_wr && !done, "R1", "strobes after reset",
          {bus_rd, bus_wr, done}, 0);
    check(acc_out == 0 && {flag_n, flag_v, flag_z, flag_c} == 0, "R1",
          "results after reset", {acc_out, flag_n, flag_v, flag_z, flag_c}, 0);

    // R4 R5 R6: every modification of 0x25 with carry clear and set
    for (int op = 0; op < 6; op++) begin
      run_op(4'(op), 16'h2004, 8'h25, 1'b0, 1'b0, 8'h5A, "R5");
      run_op(4'(op), 16'h2004, 8'h25, 1'b1, 1'b1, 8'h5A, "R6");
    end
    // R6 wrap cases
    run_op(4'd4, 16'h0010, 8'h00, 1'b0, 1'b0, 8'h11, "R6");
    run_op(4'd5, 16'h0011, 8'hFF, 1'b1, 1'b0, 8'h11, "R6");
    run_op(4'd1, 16'h0012, 8'h80, 1'b0, 1'b0, 8'h11, "R6");
    run_op(4'd3, 16'h0013, 8'h01, 1'b0, 1'b0, 8'h11, "R6");
    // R7 logic merges
    run_op(4'd8,  16'h0020, 8'h25, 1'b0, 1'b0, 8'h81, "R7");
    run_op(4'd9,  16'h0021, 8'h25, 1'b1, 1'b1, 8'hF0, "R7");
    run_op(4'd10, 16'h0022, 8'h25, 1'b0, 1'b0, 8'h12, "R7");
    // R8 add with carry: overflow and carry-out cases
    run_op(4'd11, 16'h0030, 8'h25, 1'b0, 1'b0, 8'h7F, "R8");
    run_op(4'd11, 16'h0031, 8'h25, 1'b1, 1'b0, 8'h80, "R8");
    run_op(4'd11, 16'h0032, 8'h03, 1'b0, 1'b1, 8'hFF, "R8");
    // R9 compare: equal, less, greater
    run_op(4'd12, 16'h0040, 8'h25, 1'b0, 1'b0, 8'h24, "R9");
    run_op(4'd12, 16'h0041, 8'h25, 1'b1, 1'b0, 8'h10, "R9");
    run_op(4'd12, 16'h0042, 8'h25, 1'b0, 1'b1, 8'h90, "R9");
    // R10 subtract with borrow
    run_op(4'd13, 16'h0050, 8'h25, 1'b1, 1'b0, 8'h30, "R10");
    run_op(4'd13, 16'h0051, 8'h25, 1'b0, 1'b0, 8'h26, "R10");
    run_op(4'd13, 16'h0052, 8'h25, 1'b1, 1'b0, 8'h80, "R10");

    // R11: second start during the read cycle is ignored
    begin
      logic [7:0] m, ao;
      logic [3:0] fl;
      item_t it;
      ref_calc(4'd5, 8'h40, 1'b0, 1'b0, 8'h01, m, ao, fl);
      mem[8'h60] = 8'h40;
      mem[8'h61] = 8'h77;
      it.addr = 16'h0060; it.acc = ao; it.flg = fl; it.req = "R11";
      it.kind = 0; it.data = 0; exp_q.push_back(it);
      it.kind = 1; it.data = 8'h40; exp_q.push_back(it);
      it.kind = 1; it.data = m; exp_q.push_back(it);
      it.kind = 2; it.data = 0; exp_q.push_back(it);
      op_code = 4'd5; addr_in = 16'h0060; carry_in = 0; v_in = 0; acc_in = 8'h01;
      start = 1'b1;
      @(negedge clk);
      op_code = 4'd8; addr_in = 16'h0061; acc_in = 8'hFF;  // still asserted: busy
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      check(mem[8'h61] == 8'h77, "R11", "untouched address", mem[8'h61], 8'h77);
    end

    // R12: reserved codes start nothing
    for (int rc = 6; rc < 8; rc++) begin
      logic [7:0] acc_before;
      acc_before = acc_out;
      ev0 = events;
      op_code = 4'(rc); addr_in = 16'h0070; acc_in = 8'hC3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      check(events == ev0, "R12", "bus events after reserved code", events, ev0);
      check(acc_out == acc_before, "R12", "acc_out held", acc_out, acc_before);
    end

    check(exp_q.size() == 0, "R2", "expected items left over", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule